// File: doc/BRIEF.md
# Burst-Trapping Syndrome Decoder with Sync-Header Rebuild

This block sits behind block alignment and descrambling on the receive side of a 10G backplane link. It accepts codewords of `NW` transcoded 65-bit words followed by 32 parity bits. The default of 32 words gives 2112 bits protected by the generator g(x) = x^32 + x^23 + x^21 + x^11 + x^2 + 1. The syndrome of each block is accumulated as the words stream in. The block is held in one of two buffer banks. The syndrome is then divided by x repeatedly until a burst of at most 11 bits is exposed in its low bits. The shift count at that point locates the burst.

On the way out, the located burst is cancelled in the words it touches. Each 65-bit word is widened back to a 66-bit word by rebuilding its two-bit sync header from the transcode bit. Every outgoing word carries a start-of-block marker and two status flags: corrected, and uncorrectable. Two saturating counters tally corrected and uncorrectable blocks. Enough division steps run in each cycle that trapping for one block ends before the next block can finish arriving. Blocks may therefore be sent back to back, and each block sees the same fixed latency.

Top module: `fec_burst_decoder`

## Requirements
- R1: While and after reset, out_valid, out_sob, out_fixed and out_bad are low and both counters read zero until a block has been decoded.
- R2: A block is one beat with in_sop high followed by NW-1 more data beats and then one parity beat that carries its 32 bits in in_word[31:0]. The first bit of the block (word 0, bit 64) is the highest-degree coefficient, and parity bit 0 is degree 0. When the received polynomial is divisible by g(x), all NW words leave unchanged, with out_fixed and out_bad low.
- R3: Any single burst of 1 to 11 adjacent bit positions anywhere in the block is removed: the output words equal the transmitted ones, and out_fixed is high on every word of the block. This holds for bursts that cross word boundaries and the data/parity boundary.
- R4: A burst confined to the parity bits leaves the data words as received and raises out_fixed.
- R5: A block is uncorrectable when no shift count j from 0 to N-1 leaves S*x^-j mod g(x) non-zero, zero in bits 31..11, and with all of its set bits at degrees below N. Such a block is passed on as received with out_bad high. out_fixed and out_bad are never both high.
- R6: Output bits [65:2] carry corrected input bits [64:1]. A set transcode bit (input bit 0) gives out_word[1:0] = 2'b01, and a clear one gives 2'b10.
- R7: The first word of a block is presented exactly ceil(N/ceil(N/NW))+1 clock edges after the edge that accepts its parity beat (33 for the default). The NW words follow on consecutive cycles, with out_sob high on the first only. Blocks may arrive back to back with no idle beat between them.
- R8: cnt_fixed and cnt_bad each step by one in the cycle the start of a corrected or uncorrectable block is presented, and each stops at its all-ones value.
- R9: A beat with in_sop high discards any partly received block and starts a new one. Beats that arrive after a parity beat without in_sop are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_sop | input | 1 | Beat is the first word of a block |
| in_word | input | 65 | Transcoded word; parity in [31:0] on the last beat |
| out_valid | output | 1 | Output word present |
| out_sob | output | 1 | Output word is the first of its block |
| out_word | output | 66 | Rebuilt word, sync header in [1:0] |
| out_fixed | output | 1 | Block had a burst that was corrected |
| out_bad | output | 1 | Block could not be corrected |
| cnt_fixed | output | CW | Saturating count of corrected blocks |
| cnt_bad | output | CW | Saturating count of uncorrectable blocks |

## Verification
The bench builds the decoder with NW = 32, the full 2112-bit code, so that the burst-correction guarantee is tested on the real code length. Bursts are placed at the top degree, at word seams, at the data/parity seam and inside the parity. CW is set to 3, so both counters reach their all-ones value of 7 after a few dozen blocks and saturation is observed. Blocks are sent both back to back and with idle gaps, which checks the fixed latency and the two-bank reuse under the tightest spacing.

// File: rtl/fec_burst_decoder.sv
module fec_burst_decoder #(
  parameter int NW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [64:0]   in_word,
  output logic          out_valid,
  output logic          out_sob,
  output logic [65:0]   out_word,
  output logic          out_fixed,
  output logic          out_bad,
  output logic [CW-1:0] cnt_fixed,
  output logic [CW-1:0] cnt_bad
);
  localparam int N     = NW * 65 + 32;
  localparam int STEPS = (N + NW - 1) / NW;
  localparam int TC    = (N + STEPS - 1) / STEPS;
  localparam int IW    = $clog2(NW + 2);
  localparam int AW    = $clog2(2 * NW);
  localparam int JW    = $clog2(N);
  localparam int TW    = $clog2(TC + 1);
  localparam logic [31:0] GP = 32'h00A00805;

  function automatic logic [31:0] mul_x(input logic [31:0] s, input logic b);
    return {s[30:0], b} ^ (s[31] ? GP : 32'd0);
  endfunction

  function automatic logic [31:0] div_x(input logic [31:0] s);
    logic [31:0] t;
    t = s[0] ? (s ^ GP) : s;
    return {s[0], t[31:1]};
  endfunction

  logic [64:0]   mem [2*NW];
  logic          wr_bank;
  logic [IW-1:0] wr_idx;
  logic [31:0]   acc;

  logic          tr_run, tr_bank, tr_nz, fnd;
  logic [TW-1:0] tr_cnt;
  logic [31:0]   tr_s;
  logic [JW-1:0] fpos;
  logic [10:0]   fpat;

  logic          o_run, o_bank, r_fix, r_bad;
  logic [IW-1:0] o_idx;
  logic [JW-1:0] r_pos;
  logic [10:0]   r_pat;

  wire [IW-1:0] eff_idx  = in_sop ? '0 : wr_idx;
  wire          beat     = in_valid && (in_sop || wr_idx <= IW'(NW));
  wire          par_beat = beat && eff_idx == IW'(NW);
  wire          tr_last  = tr_run && tr_cnt == TW'(TC - 1);
  wire [AW-1:0] wa = wr_bank ? AW'(NW) + AW'(eff_idx) : AW'(eff_idx);
  wire [AW-1:0] ra = o_bank ? AW'(NW) + AW'(o_idx) : AW'(o_idx);

  logic [31:0] acc_n;
  always_comb begin
    acc_n = in_sop ? '0 : acc;
    if (eff_idx == IW'(NW))
      for (int i = 31; i >= 0; i--) acc_n = mul_x(acc_n, in_word[i]);
    else
      for (int i = 64; i >= 0; i--) acc_n = mul_x(acc_n, in_word[i]);
  end

  logic [31:0]   b_s;
  logic          b_hit;
  logic [JW-1:0] b_pos;
  logic [10:0]   b_pat;
  always_comb begin
    b_s = tr_s; b_hit = fnd; b_pos = fpos; b_pat = fpat;
    for (int k = 0; k < STEPS; k++) begin
      int j;
      j = int'(tr_cnt) * STEPS + k;
      if (!b_hit && j < N && b_s != 0 && b_s[31:11] == 0 &&
          (j + 11 <= N || (b_s[10:0] >> (N - j)) == 11'd0)) begin
        b_hit = 1'b1; b_pos = JW'(j); b_pat = b_s[10:0];
      end
      b_s = div_x(b_s);
    end
  end

  logic [64:0] fixw;
  always_comb begin
    int sh;
    logic [75:0] v;
    sh = int'(r_pos) + 11 - (32 + (NW - 1 - int'(o_idx)) * 65);
    v = '0;
    if (sh >= 0 && sh <= 75) v = {65'd0, r_pat} << sh;
    fixw = mem[ra] ^ v[75:11];
  end

  always_ff @(posedge clk)
    if (beat && eff_idx < IW'(NW)) mem[wa] <= in_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank <= 1'b0; wr_idx <= IW'(NW + 1); acc <= '0;
      tr_run <= 1'b0; tr_bank <= 1'b0; tr_nz <= 1'b0; fnd <= 1'b0;
      tr_cnt <= '0; tr_s <= '0; fpos <= '0; fpat <= '0;
      o_run <= 1'b0; o_bank <= 1'b0; r_fix <= 1'b0; r_bad <= 1'b0;
      o_idx <= '0; r_pos <= '0; r_pat <= '0;
      out_valid <= 1'b0; out_sob <= 1'b0; out_word <= '0;
      out_fixed <= 1'b0; out_bad <= 1'b0; cnt_fixed <= '0; cnt_bad <= '0;
    end else begin
      if (beat) begin
        wr_idx <= eff_idx + 1'b1;
        acc    <= acc_n;
      end
      if (par_beat) begin
        tr_run <= 1'b1; tr_cnt <= '0; tr_s <= acc_n; tr_nz <= acc_n != 0;
        fnd <= 1'b0; fpos <= '0; fpat <= '0;
        tr_bank <= wr_bank; wr_bank <= ~wr_bank;
      end else if (tr_run) begin
        tr_s <= b_s; fnd <= b_hit; fpos <= b_pos; fpat <= b_pat;
        tr_cnt <= tr_cnt + 1'b1;
        if (tr_last) tr_run <= 1'b0;
      end

      out_valid <= o_run;
      out_sob   <= o_run && o_idx == '0;
      if (o_run) begin
        out_word  <= {fixw[64:1], fixw[0] ? 2'b01 : 2'b10};
        out_fixed <= r_fix;
        out_bad   <= r_bad;
        if (o_idx == IW'(NW - 1)) o_run <= 1'b0;
        else o_idx <= o_idx + 1'b1;
        if (o_idx == '0) begin
          if (r_fix && cnt_fixed != '1) cnt_fixed <= cnt_fixed + 1'b1;
          if (r_bad && cnt_bad != '1) cnt_bad <= cnt_bad + 1'b1;
        end
      end
      if (tr_last) begin
        o_run <= 1'b1; o_idx <= '0; o_bank <= tr_bank;
        r_pos <= b_pos; r_pat <= b_pat;
        r_fix <= b_hit; r_bad <= tr_nz && !b_hit;
      end
    end
  end
endmodule

// File: rtl/fec_burst_decoder_chk.sv
module fec_burst_decoder_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_sob,
  input logic [65:0]   out_word,
  input logic          out_fixed,
  input logic          out_bad,
  input logic [CW-1:0] cnt_fixed,
  input logic [CW-1:0] cnt_bad
);
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_fixed && out_bad));

  p_header_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[1:0] == 2'b01 || out_word[1:0] == 2'b10));

  p_sob_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sob |-> out_valid);

  p_sob_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sob |=> (out_valid && !out_sob));

  p_fix_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fixed == '1) |=> (cnt_fixed == '1));

  p_bad_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_bad == '1) |=> (cnt_bad == '1));

  p_fix_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fixed != $past(cnt_fixed)) |-> (out_sob && out_fixed));

  p_bad_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_bad != $past(cnt_bad)) |-> (out_sob && out_bad));
endmodule

bind fec_burst_decoder fec_burst_decoder_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sob(out_sob),
  .out_word(out_word), .out_fixed(out_fixed), .out_bad(out_bad),
  .cnt_fixed(cnt_fixed), .cnt_bad(cnt_bad)
);

// File: tb/sim_fec_burst_decoder.sv
module sim_fec_burst_decoder;
  localparam int CLK_NS = 10;
  localparam int NW = 32;
  localparam int CW = 3;
  localparam int N = NW * 65 + 32;
  localparam int STEPS = (N + NW - 1) / NW;
  localparam int TC = (N + STEPS - 1) / STEPS;
  localparam int CMAX = (1 << CW) - 1;
  localparam logic [31:0] GP = 32'h00A00805;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_sop = 1'b0;
  logic [64:0] in_word = '0;
  logic out_valid, out_sob, out_fixed, out_bad;
  logic [65:0] out_word;
  logic [CW-1:0] cnt_fixed, cnt_bad;

  fec_burst_decoder #(.NW(NW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_word(in_word), .out_valid(out_valid), .out_sob(out_sob),
    .out_word(out_word), .out_fixed(out_fixed), .out_bad(out_bad),
    .cnt_fixed(cnt_fixed), .cnt_bad(cnt_bad));

  always #(CLK_NS / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nrun = 0, nfail = 0, ef = 0, eb = 0;
  bit done = 1'b0;
  logic [64:0] qw[$];
  logic [2:0]  qf[$];
  int          qt[$];
  string       qr[$];
  logic [64:0] dat [NW];
  logic [N-1:0] err;

  task automatic check(bit ok, string req, string what, logic [65:0] act, logic [65:0] exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mulx(logic [31:0] s, logic b);
    logic [31:0] r;
    r = {s[30:0], 1'b0} ^ {31'd0, b};
    if (s[31]) r = r ^ GP;
    return r;
  endfunction

  function automatic logic [31:0] divx(logic [31:0] s);
    logic [31:0] t;
    t = s;
    if (s[0]) t = t ^ GP;
    return {s[0], t[31:1]};
  endfunction

  always @(negedge clk) begin
    logic [64:0] w;
    logic [2:0] f;
    int t;
    string r;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (qw.size() == 0) check(1'b0, "R7", "unexpected word", out_word, '0);
        else begin
          w = qw.pop_front(); f = qf.pop_front(); t = qt.pop_front(); r = qr.pop_front();
          check(out_word[65:2] == w[64:1], r, "payload", out_word, {w[64:1], 2'b00});
          check(out_word[1:0] == (w[0] ? 2'b01 : 2'b10), "R6", "sync header",
                66'(out_word[1:0]), 66'(w[0] ? 2'b01 : 2'b10));
          check(out_fixed == f[1] && out_bad == f[0], r, "flags",
                66'({out_fixed, out_bad}), 66'(f[1:0]));
          check(out_sob == f[2], "R7", "start marker", 66'(out_sob), 66'(f[2]));
          if (f[2]) begin
            check(cyc == t, "R7", "first word cycle", 66'(cyc), 66'(t));
            if (f[1] && ef < CMAX) ef++;
            if (f[0] && eb < CMAX) eb++;
          end
        end
      end
      check(int'(cnt_fixed) == ef && int'(cnt_bad) == eb, "R8", "counters",
            66'({cnt_fixed, cnt_bad}), 66'({ef[CW-1:0], eb[CW-1:0]}));
    end
  end

  always @(posedge clk)
    if (cyc == 200000 && !done) begin
      done = 1'b1;
      check(1'b0, "R7", "watchdog expired", 66'(qw.size()), '0);
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end

  task automatic rand_data();
    for (int w = 0; w < NW; w++) dat[w] = {$urandom, $urandom, $urandom};
  endtask

  task automatic set_burst(int p, int len);
    logic [10:0] pat;
    pat = 11'($urandom);
    pat[0] = 1'b1;
    pat[len-1] = 1'b1;
    err = '0;
    for (int k = 0; k < len; k++) err[p+k] = pat[k];
  endtask

  task automatic send_block(string req, bit genuine, int gap);
    logic [N-1:0] cw, rx, fv;
    logic [31:0] s, t;
    bit fx, bd, hit;
    int tp;
    cw = '0;
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 65; i++) cw[32 + (NW-1-w)*65 + i] = dat[w][i];
    s = '0;
    for (int d = N - 1; d >= 32; d--) s = mulx(s, cw[d]);
    for (int k = 0; k < 32; k++) s = mulx(s, 1'b0);
    cw[31:0] = s;
    rx = cw ^ err;
    s = '0;
    for (int d = N - 1; d >= 0; d--) s = mulx(s, rx[d]);
    fx = 1'b0; bd = 1'b0; fv = rx;
    if (genuine) begin
      fv = cw; fx = (err != '0);
    end else if (s != 0) begin
      hit = 1'b0; t = s;
      for (int j = 0; j < N && !hit; j++) begin
        if (t != 0 && t[31:11] == 0 && (j + 11 <= N || (t[10:0] >> (N - j)) == 11'd0)) begin
          hit = 1'b1;
          for (int k = 0; k < 11; k++) if (j + k < N) fv[j+k] = fv[j+k] ^ t[k];
        end
        t = divx(t);
      end
      fx = hit; bd = !hit;
    end
    for (int w = 0; w < NW; w++) begin
      qw.push_back(fv[32 + (NW-1-w)*65 +: 65]);
      qf.push_back({w == 0, fx, bd});
      qr.push_back(req);
    end
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (w == 0); in_word = rx[32 + (NW-1-w)*65 +: 65];
    end
    @(negedge clk);
    in_sop = 1'b0; in_word = {33'd0, rx[31:0]};
    tp = cyc + 1 + TC + 1;
    for (int w = 0; w < NW; w++) qt.push_back(w == 0 ? tp : 0);
    repeat (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    err = '0;
    repeat (4) @(negedge clk);
    check(!out_valid && !out_sob && !out_fixed && !out_bad, "R1", "outputs in reset",
          66'({out_valid, out_sob, out_fixed, out_bad}), '0);
    check(cnt_fixed == '0 && cnt_bad == '0, "R1", "counters in reset",
          66'({cnt_fixed, cnt_bad}), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && cnt_fixed == '0, "R1", "idle after reset", 66'(out_valid), '0);

    // R2: clean blocks, back to back then gapped
    for (int b = 0; b < 3; b++) begin rand_data(); send_block("R2", 1'b1, b == 2 ? 4 : 0); end

    // R3: bursts at seams, top degree, random spots
    begin
      int ps[12];
      int ls[12];
      ps = '{32, 32 + 65*5 - 5, N - 11, N - 1, 700, 1234, 2000, 32 + 65*31 - 3, 97, 1500, 400, 1888};
      ls = '{1, 11, 11, 1, 7, 10, 11, 6, 11, 3, 9, 2};
      for (int b = 0; b < 12; b++) begin
        rand_data(); set_burst(ps[b], ls[b]);
        send_block("R3", 1'b1, (b % 3 == 0) ? 2 : 0);
      end
      for (int b = 0; b < 4; b++) begin
        rand_data(); set_burst(32 + int'($urandom % (N - 43)), 1 + int'($urandom % 11));
        send_block("R3", 1'b1, 0);
      end
    end

    // R4: parity-only burst; R3: burst straddling parity and data
    rand_data(); set_burst(5, 8); send_block("R4", 1'b1, 0);
    rand_data(); set_burst(0, 11); send_block("R4", 1'b1, 1);
    rand_data(); set_burst(26, 11); send_block("R3", 1'b1, 0);

    // R5: scattered errors, decided by the trapping rule
    for (int b = 0; b < 12; b++) begin
      int a;
      rand_data();
      a = 40 + int'($urandom % 800);
      err = '0;
      err[a] = 1'b1;
      err[a + 700 + int'($urandom % 500)] = 1'b1;
      err[a + 300] = 1'b1;
      send_block("R5", 1'b0, b % 2);
    end

    // R9: restart mid-block, then stray beats after parity
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (k == 0); in_word = {$urandom, $urandom, $urandom};
    end
    err = '0; rand_data(); send_block("R9", 1'b1, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_word = {$urandom, $urandom, $urandom};
    end
    @(negedge clk);
    in_valid = 1'b0;
    rand_data(); set_burst(300, 4); send_block("R9", 1'b1, 0);

    @(negedge clk);
    in_valid = 1'b0;
    while (qw.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(int'(cnt_fixed) == CMAX, "R8", "fixed counter saturated", 66'(cnt_fixed), 66'(CMAX));
    check(!out_valid, "R9", "no stray output", 66'(out_valid), '0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule